// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous dynamic RAM alive for a memory controller. After reset it waits out a power-up settling time, then demands a short burst of initialization refreshes. Only when the controller has served all of them does it raise `ready`. From then on it requests one CAS-before-RAS refresh per refresh interval, so that the device's internal row counter walks every row within the retention period. It never supplies a row address.

Requests that the controller has not yet served pile up in a saturating debt counter. When that debt reaches a set limit, an urgency flag tells the controller to stop postponing refresh. On command the block also hands the device over to self-refresh. It holds the controller in that state for a minimum time, and on exit it keeps `ready` low for a recovery window before normal refresh resumes.

All times are given in nanoseconds and converted to clock cycles from the clock-period parameter. Minimum waits are rounded up. The refresh interval, which is a maximum, is rounded down.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset is released, `ref_req` and `ready` stay low for exactly ceil(STARTUP_NS/CLK_NS) clock edges. Default: 200 us.
- R2: After the start-up wait, `ref_req` stays high until INIT_CYCLES grants have been accepted. `ready` rises on the clock edge that accepts the last of them.
- R3: Once `ready` is high, the refresh debt gains one every floor(T/CLK_NS) cycles. T is REFI_STD_NS (15625 ns, 1024 rows in 16 ms) when LOW_POWER is 0, and REFI_LP_NS (125000 ns, 1024 rows in 128 ms) when LOW_POWER is 1. The first increment comes that many edges after `ready` rises.
- R4: `ref_req` is high exactly while the debt is nonzero in the initialization and running phases. A `ref_gnt` pulse lowers the debt by one. A grant that lands on the same edge as an interval increment leaves the debt unchanged. A grant with zero debt is ignored. The debt saturates at 2**DEBT_W-1.
- R5: `ref_urgent` is high exactly when the debt is at least URGENT_LIMIT.
- R6: `sr_enter_req` is acted on only while `ready` is high. On acceptance, `sr_hold` rises on the next edge, `ready` and `ref_req` go low, and the debt is cleared.
- R7: `sr_hold` stays high for at least ceil(SR_MIN_NS/CLK_NS) cycles. It falls on the first edge at which `sr_exit_req` is high and that minimum has elapsed. `sr_exit_req` has no effect outside self-refresh.
- R8: After `sr_hold` falls, `ready` stays low for exactly ceil(SR_EXIT_NS/CLK_NS) cycles. Grants during self-refresh and recovery are ignored. The refresh interval restarts from zero when `ready` rises again.
- R9: While reset is high, `ref_req`, `ref_urgent`, `ready` and `sr_hold` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | One-cycle pulse: the controller has executed one CAS-before-RAS refresh |
| sr_enter_req | input | 1 | Command to place the device in self-refresh |
| sr_exit_req | input | 1 | Command to leave self-refresh (acted on once the minimum hold time is met) |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Refresh debt has reached the postponement limit |
| ready | output | 1 | Device initialized and available for normal accesses |
| sr_hold | output | 1 | Controller must keep the device in self-refresh (RAS held low after CAS) |

## Verification
Two functions can fall on the same edge. One is the interval timer adding a refresh owed. The other is the controller's grant paying one off. The bench places a grant exactly on an interval boundary by tracking the boundary arithmetically from the edge at which `ready` rose, and expects the debt to hold steady: `ref_req` stays high and clears after exactly one more grant. A second collision, a self-refresh entry while a refresh is still owed, is judged by `ref_req` staying low through recovery and needing just one grant after the first new interval.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT,
        ST_RUN,
        ST_SELF,
        ST_RECOVER
    } rs_state_e;

    typedef struct packed {
        logic phase_clr;
        logic debt_load;
        logic debt_clr;
        logic run;
        logic gnt_en;
    } rs_ctrl_t;

    // Minimum waits: round up so no minimum is shortened.
    function automatic int ceil_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Maximum intervals: round down so no deadline is missed.
    function automatic int floor_cycles(input int ns, input int clk_ns);
        int c;
        c = ns / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rs_cycle_counter.sv
module rs_cycle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!hit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs_debt.sv
module rs_debt #(
    parameter int W         = 4,
    parameter int INIT_CNT  = 8,
    parameter int URG_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clr,
    input  logic tick,
    input  logic gnt,
    input  logic gnt_en,
    output logic nonzero,
    output logic urgent,
    output logic drained
);
    localparam int MAXV   = (1 << W) - 1;
    localparam int INIT_V = (INIT_CNT > MAXV) ? MAXV : INIT_CNT;
    localparam int LIM_V  = (URG_LIMIT > MAXV) ? MAXV : URG_LIMIT;

    logic [W-1:0] debt;
    logic         take;

    assign nonzero = (debt != '0);
    assign take    = gnt && gnt_en && nonzero;
    assign urgent  = ({1'b0, debt} >= (W+1)'(LIM_V));
    assign drained = take && !tick && (debt == W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            debt <= '0;
        end else if (load) begin
            debt <= W'(INIT_V);
        end else begin
            unique case ({tick, take})
                2'b10:   if (debt != W'(MAXV)) debt <= debt + 1'b1;
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end
endmodule

// File: rtl/rs_sequencer.sv
module rs_sequencer
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      phase_hit,
    input  logic      init_drained,
    input  logic      sr_enter,
    input  logic      sr_exit,
    output rs_state_e state,
    output rs_ctrl_t  ctrl
);
    rs_state_e nxt;

    always_comb begin
        nxt  = state;
        ctrl = '0;
        unique case (state)
            ST_POWERUP: begin
                if (phase_hit) begin
                    nxt            = ST_INIT;
                    ctrl.debt_load = 1'b1;
                end
            end
            ST_INIT: begin
                ctrl.gnt_en = 1'b1;
                if (init_drained) nxt = ST_RUN;
            end
            ST_RUN: begin
                ctrl.gnt_en = 1'b1;
                ctrl.run    = 1'b1;
                if (sr_enter) begin
                    nxt            = ST_SELF;
                    ctrl.debt_clr  = 1'b1;
                    ctrl.phase_clr = 1'b1;
                end
            end
            ST_SELF: begin
                if (sr_exit && phase_hit) begin
                    nxt            = ST_RECOVER;
                    ctrl.phase_clr = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (phase_hit) nxt = ST_RUN;
            end
            default: nxt = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_POWERUP;
        else     state <= nxt;
    end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import rs_pkg::*;
#(
    parameter int CLK_NS       = 20,
    parameter int STARTUP_NS   = 200000,
    parameter int INIT_CYCLES  = 8,
    parameter bit LOW_POWER    = 1'b0,
    parameter int REFI_STD_NS  = 15625,
    parameter int REFI_LP_NS   = 125000,
    parameter int SR_MIN_NS    = 100000,
    parameter int SR_EXIT_NS   = 110,
    parameter int DEBT_W       = 4,
    parameter int URGENT_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic ready,
    output logic sr_hold
);
    localparam int STARTUP_CYC = ceil_cycles(STARTUP_NS, CLK_NS);
    localparam int SR_MIN_CYC  = ceil_cycles(SR_MIN_NS, CLK_NS);
    localparam int REC_CYC     = ceil_cycles(SR_EXIT_NS, CLK_NS);
    localparam int REFI_NS     = LOW_POWER ? REFI_LP_NS : REFI_STD_NS;
    localparam int REFI_CYC    = floor_cycles(REFI_NS, CLK_NS);
    localparam int PH_MAX      = max3(STARTUP_CYC, SR_MIN_CYC, REC_CYC);
    localparam int PH_W        = $clog2(PH_MAX + 1);
    localparam int REFI_W      = $clog2(REFI_CYC + 1);

    rs_state_e   state;
    rs_ctrl_t    ctrl;
    logic [PH_W-1:0] phase_limit;
    logic        phase_hit;
    logic        refi_hit;
    logic        tick;
    logic        debt_nz;
    logic        drained;

    always_comb begin
        unique case (state)
            ST_POWERUP: phase_limit = PH_W'(STARTUP_CYC - 1);
            ST_SELF:    phase_limit = PH_W'(SR_MIN_CYC - 1);
            ST_RECOVER: phase_limit = PH_W'(REC_CYC - 1);
            default:    phase_limit = '0;
        endcase
    end

    rs_cycle_counter #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl.phase_clr),
        .limit (phase_limit),
        .hit   (phase_hit)
    );

    rs_cycle_counter #(.W(REFI_W)) u_interval (
        .clk   (clk),
        .rst   (rst),
        .clr   (!ctrl.run || refi_hit),
        .limit (REFI_W'(REFI_CYC - 1)),
        .hit   (refi_hit)
    );

    assign tick = ctrl.run && refi_hit;

    rs_debt #(
        .W         (DEBT_W),
        .INIT_CNT  (INIT_CYCLES),
        .URG_LIMIT (URGENT_LIMIT)
    ) u_debt (
        .clk     (clk),
        .rst     (rst),
        .load    (ctrl.debt_load),
        .clr     (ctrl.debt_clr),
        .tick    (tick),
        .gnt     (ref_gnt),
        .gnt_en  (ctrl.gnt_en),
        .nonzero (debt_nz),
        .urgent  (ref_urgent),
        .drained (drained)
    );

    rs_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .phase_hit    (phase_hit),
        .init_drained (drained),
        .sr_enter     (sr_enter_req),
        .sr_exit      (sr_exit_req),
        .state        (state),
        .ctrl         (ctrl)
    );

    assign ready   = (state == ST_RUN);
    assign sr_hold = (state == ST_SELF);
    assign ref_req = debt_nz && ctrl.gnt_en;
endmodule

// File: rtl/refresh_scheduler_checker.sv
module refresh_scheduler_checker #(
    parameter int SR_MIN_CYC = 1
) (
    input logic clk,
    input logic rst,
    input logic ref_req,
    input logic ref_urgent,
    input logic ready,
    input logic sr_hold
);
    logic [31:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)          hold_cnt <= '0;
        else if (sr_hold) hold_cnt <= hold_cnt + 1;
        else              hold_cnt <= '0;
    end

    // R9: reset state
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!ref_req && !ref_urgent && !ready && !sr_hold));

    // R5: urgency only with a pending request
    assert_urgent_has_req_R5: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);

    // R6: self-refresh excludes ready and requests
    assert_hold_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        sr_hold |-> (!ready && !ref_req));

    // R6: entry only from ready
    assert_enter_from_ready_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_hold) |-> $past(ready));

    // R7: minimum hold time respected
    assert_hold_minimum_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_hold) |-> (hold_cnt >= SR_MIN_CYC));

    // R8: leaving self-refresh never returns straight to ready
    assert_recover_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_hold) |-> !ready);
endmodule

bind refresh_scheduler refresh_scheduler_checker #(.SR_MIN_CYC(SR_MIN_CYC)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .ready      (ready),
    .sr_hold    (sr_hold)
);

// File: tb/refresh_scheduler_bench.sv
module refresh_scheduler_bench;
    localparam int CLK_NS   = 20;
    localparam int ST_NS    = 190;
    localparam int INIT_N   = 3;
    localparam int REFI_NS  = 1010;
    localparam int SRMIN_NS = 150;
    localparam int EXIT_NS  = 50;
    localparam int DW       = 4;
    localparam int URG      = 4;

    localparam int EXP_START = (ST_NS + CLK_NS - 1) / CLK_NS;
    localparam int EXP_REFI  = REFI_NS / CLK_NS;
    localparam int EXP_SRMIN = (SRMIN_NS + CLK_NS - 1) / CLK_NS;
    localparam int EXP_REC   = (EXIT_NS + CLK_NS - 1) / CLK_NS;
    localparam int DEBT_MAX  = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
    logic ref_req, ref_urgent, ready, sr_hold;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int run0 = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refresh_scheduler #(
        .CLK_NS(CLK_NS), .STARTUP_NS(ST_NS), .INIT_CYCLES(INIT_N),
        .LOW_POWER(1'b0), .REFI_STD_NS(REFI_NS), .REFI_LP_NS(REFI_NS * 8),
        .SR_MIN_NS(SRMIN_NS), .SR_EXIT_NS(EXIT_NS),
        .DEBT_W(DW), .URGENT_LIMIT(URG)
    ) u_refresh_scheduler (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent),
        .ready(ready), .sr_hold(sr_hold)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic grant();
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
    endtask

    task automatic sync_tick();
        do step(); while (((cyc - run0) % EXP_REFI) != 0);
    endtask

    initial begin
        int n;
        int m;
        repeat (3) step();
        check("R9 ready in reset", ready, 0);
        check("R9 ref_req in reset", ref_req, 0);
        check("R9 sr_hold in reset", sr_hold, 0);
        check("R9 urgent in reset", ref_urgent, 0);

        rst = 1'b0;
        n = 0;
        do begin step(); n++; end while (!ref_req && n < 1000);
        check("R1 startup edges", n, EXP_START);
        check("R1 ready low after startup", ready, 0);

        sr_enter_req = 1'b1;
        step();
        sr_enter_req = 1'b0;
        check("R6 enter ignored before ready", sr_hold, 0);
        check("R6 init request kept", ref_req, 1);

        for (int i = 1; i < INIT_N; i++) begin
            grant();
            check("R2 ready low mid-init", ready, 0);
            check("R2 request kept mid-init", ref_req, 1);
        end
        grant();
        check("R2 ready after last init grant", ready, 1);
        check("R2 request clear after init", ref_req, 0);
        run0 = cyc;

        n = 0;
        do begin step(); n++; end while (!ref_req && n < 1000);
        check("R3 first interval edges", n, EXP_REFI);

        // grant lands on the next interval boundary
        repeat (EXP_REFI - 1) step();
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        check("R4 boundary grant keeps debt", ref_req, 1);
        check("R4 grant was on boundary", (cyc - run0) % EXP_REFI, 0);
        grant();
        check("R4 one grant clears", ref_req, 0);
        grant();
        check("R4 grant with no debt ignored", ref_req, 0);
        sync_tick();
        check("R3 request after next interval", ref_req, 1);
        grant();
        check("R4 no underflow", ref_req, 0);

        for (int d = 1; d <= URG; d++) begin
            sync_tick();
            check("R5 urgency vs debt", ref_urgent, (d >= URG) ? 1 : 0);
        end
        repeat (DEBT_MAX + 1) sync_tick();
        for (int i = 1; i < DEBT_MAX; i++) begin
            grant();
            check("R5 urgency while draining", ref_urgent,
                  ((DEBT_MAX - i) >= URG) ? 1 : 0);
        end
        check("R4 saturated debt one left", ref_req, 1);
        grant();
        check("R4 saturated debt drained", ref_req, 0);

        sr_exit_req = 1'b1;
        step();
        sr_exit_req = 1'b0;
        check("R7 exit ignored while running", ready, 1);
        check("R7 exit ignored no hold", sr_hold, 0);

        sync_tick();
        check("R6 debt pending before entry", ref_req, 1);
        sr_enter_req = 1'b1;
        step();
        sr_enter_req = 1'b0;
        sr_exit_req  = 1'b1;
        check("R6 hold after entry", sr_hold, 1);
        check("R6 ready low in self-refresh", ready, 0);
        check("R6 request low in self-refresh", ref_req, 0);
        n = 1;
        grant();
        if (sr_hold) n++;
        while (sr_hold && n < 1000) begin
            step();
            if (sr_hold) n++;
        end
        sr_exit_req = 1'b0;
        check("R7 hold length with early exit", n, EXP_SRMIN);
        m = 1;
        check("R8 request low in recovery", ref_req, 0);
        while (!ready && m < 1000) begin
            step();
            if (!ready) m++;
        end
        check("R8 recovery length", m, EXP_REC);
        run0 = cyc;
        n = 0;
        do begin step(); n++; end while (!ref_req && n < 1000);
        check("R8 interval restarted", n, EXP_REFI);
        grant();
        check("R8 debt cleared by entry", ref_req, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule